// File: doc/BRIEF.md
# Indexed Load Address Unit

This block carries out the six word-load forms of a 32-bit instruction set. An instruction word arrives together with a condition-pass flag. The block presents the base and offset register indexes to an external register file and takes the read values back in the same cycle. It then forms the memory address and holds a single word read request until the memory answers. When the answer arrives, the block issues the loaded word as a write to the destination register. For write-back forms it also issues the updated base as a write to the base register.

Three indexing modes exist: pre-indexed without base update, pre-indexed with base update, and post-indexed with base update. Each mode comes with either an immediate offset or a register offset. Evaluating the condition code, holding the register file and holding the memory are left to neighbouring blocks. A failed memory access is reported on a fault pulse, and in that case no register write takes place.

Top module: `ldidx_unit`

## Requirements
- R1: Opcode sits in instruction bits [6:0], destination index in [15:11], base index in [20:16] and offset-register index in [25:21]; `base_ridx` and `offs_ridx` show bits [20:16] and [25:21] of `instr_word` in the same cycle.
- R2: Opcode 0x01 reads memory at base plus immediate offset, then writes the loaded word to the destination register and leaves the base register unwritten.
- R3: Opcode 0x02 reads at base plus immediate offset and writes that same sum back to the base register along with the loaded word.
- R4: Opcode 0x03 reads at the unmodified base and writes base plus immediate offset back to the base register.
- R5: Opcodes 0x04, 0x05 and 0x06 behave as 0x01, 0x02 and 0x03 with the offset taken from the value of the register indexed by bits [25:21]; the sum wraps modulo 2^32 and bits [31:26] have no effect.
- R6: The immediate field is bits [31:21], zero-extended and multiplied by 4, so field value 0x7FF gives a byte offset of 8188.
- R7: An instruction accepted with `cond_pass` low is consumed with no memory request and no register write.
- R8: A response with `mem_err` high produces a one-cycle `fault` pulse and neither register write.
- R9: In a write-back mode whose destination and base indexes are equal, only the destination write occurs, carrying the loaded word.
- R10: From acceptance until the response, `mem_req` stays high with a stable `mem_addr` and `instr_ready` stays low; the write strobes pulse for exactly the one cycle after the response.
- R11: Any opcode other than 0x01 to 0x06 is consumed with no memory request and no register write.
- R12: After reset `mem_req`, `dst_we`, `base_we` and `fault` are low and `instr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_word | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition of the offered instruction holds |
| base_ridx | output | 5 | Register-file read index for the base |
| offs_ridx | output | 5 | Register-file read index for the offset register |
| base_rdata | input | DATA_W | Value of the base register |
| offs_rdata | input | DATA_W | Value of the offset register |
| mem_req | output | 1 | Word read request, held until the response |
| mem_addr | output | DATA_W | Byte address of the read |
| mem_rvalid | input | 1 | Memory response present |
| mem_rdata | input | DATA_W | Read word |
| mem_err | input | 1 | Response marks a failed access |
| dst_we | output | 1 | Destination register write strobe |
| dst_widx | output | 5 | Destination register index |
| dst_wdata | output | DATA_W | Loaded word |
| base_we | output | 1 | Base register write strobe |
| base_widx | output | 5 | Base register index |
| base_wdata | output | DATA_W | Updated base value |
| fault | output | 1 | One-cycle memory fault pulse |

## Verification
The hardest case to reach from the ports is a write-back load whose base and destination name the same register. In that case the base update must disappear while the loaded word is still written. The bench builds instruction words with equal index fields for both an immediate and a register-offset write-back form. It then checks that only the destination strobe rises. The bench also changes the register read values right after acceptance. This shows that the address and the new base come from values captured at issue time, not from the live inputs.

// File: rtl/ldidx_pkg.sv
package ldidx_pkg;

   localparam int INSTR_W   = 32;
   localparam int OPC_W     = 7;
   localparam int RIDX_W    = 5;
   localparam int IMM_W     = 11;
   localparam int IMM_SHIFT = 2;

   localparam int OPC_LSB   = 0;
   localparam int DST_LSB   = 11;
   localparam int SRC_LSB   = 16;
   localparam int ROFF_LSB  = 21;
   localparam int IMM_LSB   = 21;

   localparam logic [OPC_W-1:0] OPC_PRE_I   = 7'h01;
   localparam logic [OPC_W-1:0] OPC_PREWB_I = 7'h02;
   localparam logic [OPC_W-1:0] OPC_POST_I  = 7'h03;
   localparam logic [OPC_W-1:0] OPC_PRE_R   = 7'h04;
   localparam logic [OPC_W-1:0] OPC_PREWB_R = 7'h05;
   localparam logic [OPC_W-1:0] OPC_POST_R  = 7'h06;

   typedef enum logic [1:0] {
      IDX_PRE    = 2'd0,
      IDX_PRE_WB = 2'd1,
      IDX_POST   = 2'd2
   } idx_mode_e;

   typedef struct packed {
      logic              is_load;
      idx_mode_e         mode;
      logic              reg_off;
      logic [RIDX_W-1:0] dst;
      logic [RIDX_W-1:0] src;
      logic [RIDX_W-1:0] roff;
      logic [IMM_W-1:0]  imm;
   } ld_op_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } ld_state_e;

endpackage

// File: rtl/ldidx_decode.sv
module ldidx_decode
   import ldidx_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output ld_op_t             op
);

   logic [OPC_W-1:0] opc;
   logic             unused_cond;

   assign opc         = instr[OPC_LSB +: OPC_W];
   assign unused_cond = ^instr[DST_LSB-1:OPC_LSB+OPC_W];

   always_comb begin
      op.dst  = instr[DST_LSB  +: RIDX_W];
      op.src  = instr[SRC_LSB  +: RIDX_W];
      op.roff = instr[ROFF_LSB +: RIDX_W];
      op.imm  = instr[IMM_LSB  +: IMM_W];
      op.is_load = 1'b1;
      op.reg_off = 1'b0;
      op.mode    = IDX_PRE;
      case (opc)
         OPC_PRE_I:   begin op.mode = IDX_PRE;    op.reg_off = 1'b0; end
         OPC_PREWB_I: begin op.mode = IDX_PRE_WB; op.reg_off = 1'b0; end
         OPC_POST_I:  begin op.mode = IDX_POST;   op.reg_off = 1'b0; end
         OPC_PRE_R:   begin op.mode = IDX_PRE;    op.reg_off = 1'b1; end
         OPC_PREWB_R: begin op.mode = IDX_PRE_WB; op.reg_off = 1'b1; end
         OPC_POST_R:  begin op.mode = IDX_POST;   op.reg_off = 1'b1; end
         default:     op.is_load = 1'b0;
      endcase
   end

endmodule

// File: rtl/ldidx_addr.sv
module ldidx_addr
   import ldidx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  ld_op_t            op,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] offr_val,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] new_base
);

   localparam int EXT_W = IMM_W + IMM_SHIFT;

   logic [DATA_W-1:0] imm_off;
   logic [DATA_W-1:0] offset;
   logic [DATA_W-1:0] sum;

   generate
      if (DATA_W > EXT_W) begin : g_pad
         assign imm_off = {{(DATA_W-EXT_W){1'b0}}, op.imm, {IMM_SHIFT{1'b0}}};
      end else if (DATA_W == EXT_W) begin : g_exact
         assign imm_off = {op.imm, {IMM_SHIFT{1'b0}}};
      end else begin : g_bad
         $error("ldidx_addr: DATA_W too narrow for the scaled immediate");
         assign imm_off = '0;
      end
   endgenerate

   assign offset   = op.reg_off ? offr_val : imm_off;
   assign sum      = base_val + offset;
   assign addr     = (op.mode == IDX_POST) ? base_val : sum;
   assign new_base = sum;

endmodule

// File: rtl/ldidx_ctrl.sv
module ldidx_ctrl
   import ldidx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  ld_op_t            op,
   input  logic [DATA_W-1:0] addr_in,
   input  logic [DATA_W-1:0] nb_in,
   output logic              idle,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_err,
   output logic              dst_we,
   output logic [RIDX_W-1:0] dst_widx,
   output logic [DATA_W-1:0] dst_wdata,
   output logic              base_we,
   output logic [RIDX_W-1:0] base_widx,
   output logic [DATA_W-1:0] base_wdata,
   output logic              fault
);

   ld_state_e         state;
   logic [DATA_W-1:0] addr_q, nb_q, data_q;
   logic [RIDX_W-1:0] dst_q, src_q;
   logic              upd_q;
   logic              dwe_q, bwe_q, flt_q;
   logic              wants_upd;

   // base update only for write-back modes and only if it does not collide with the load target
   assign wants_upd = (op.mode != IDX_PRE) && (op.src != op.dst);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         nb_q   <= '0;
         data_q <= '0;
         dst_q  <= '0;
         src_q  <= '0;
         upd_q  <= 1'b0;
         dwe_q  <= 1'b0;
         bwe_q  <= 1'b0;
         flt_q  <= 1'b0;
      end else begin
         dwe_q <= 1'b0;
         bwe_q <= 1'b0;
         flt_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_WAIT;
                  addr_q <= addr_in;
                  nb_q   <= nb_in;
                  dst_q  <= op.dst;
                  src_q  <= op.src;
                  upd_q  <= wants_upd;
               end
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  state <= ST_IDLE;
                  if (mem_err) begin
                     flt_q <= 1'b1;
                  end else begin
                     dwe_q  <= 1'b1;
                     bwe_q  <= upd_q;
                     data_q <= mem_rdata;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle       = (state == ST_IDLE);
   assign mem_req    = (state == ST_WAIT);
   assign mem_addr   = addr_q;
   assign dst_we     = dwe_q;
   assign dst_widx   = dst_q;
   assign dst_wdata  = data_q;
   assign base_we    = bwe_q;
   assign base_widx  = src_q;
   assign base_wdata = nb_q;
   assign fault      = flt_q;

endmodule

// File: rtl/ldidx_unit.sv
module ldidx_unit
   import ldidx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   output logic              instr_ready,
   input  logic [31:0]       instr_word,
   input  logic              cond_pass,
   output logic [4:0]        base_ridx,
   output logic [4:0]        offs_ridx,
   input  logic [DATA_W-1:0] base_rdata,
   input  logic [DATA_W-1:0] offs_rdata,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_err,
   output logic              dst_we,
   output logic [4:0]        dst_widx,
   output logic [DATA_W-1:0] dst_wdata,
   output logic              base_we,
   output logic [4:0]        base_widx,
   output logic [DATA_W-1:0] base_wdata,
   output logic              fault
);

   generate
      if (DATA_W < 16) begin : g_chk_w
         $error("ldidx_unit: DATA_W must be at least 16");
      end
      if (RIDX_W != 5 || INSTR_W != 32) begin : g_chk_fmt
         $error("ldidx_unit: port widths assume 5-bit indexes and 32-bit words");
      end
   endgenerate

   ld_op_t            op;
   logic [DATA_W-1:0] addr_c, nb_c;
   logic              idle, start;

   ldidx_decode u_dec (
      .instr (instr_word),
      .op    (op)
   );

   ldidx_addr #(.DATA_W(DATA_W)) u_addr (
      .op       (op),
      .base_val (base_rdata),
      .offr_val (offs_rdata),
      .addr     (addr_c),
      .new_base (nb_c)
   );

   assign instr_ready = idle;
   assign start       = instr_valid & idle & op.is_load & cond_pass;
   assign base_ridx   = op.src;
   assign offs_ridx   = op.roff;

   ldidx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op         (op),
      .addr_in    (addr_c),
      .nb_in      (nb_c),
      .idle       (idle),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_err    (mem_err),
      .dst_we     (dst_we),
      .dst_widx   (dst_widx),
      .dst_wdata  (dst_wdata),
      .base_we    (base_we),
      .base_widx  (base_widx),
      .base_wdata (base_wdata),
      .fault      (fault)
   );

endmodule

// File: rtl/ldidx_chk.sv
module ldidx_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic              instr_ready,
   input logic [31:0]       instr_word,
   input logic              cond_pass,
   input logic              mem_req,
   input logic [DATA_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              mem_err,
   input logic              dst_we,
   input logic [4:0]        dst_widx,
   input logic              base_we,
   input logic [4:0]        base_widx,
   input logic              fault
);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !instr_ready);

   // R10
   write_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> $past(mem_req && mem_rvalid && !mem_err));

   // R8
   fault_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ($past(mem_req && mem_rvalid && mem_err) && !dst_we && !base_we));

   // R9
   base_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |-> (dst_we && (base_widx != dst_widx)));

   // R7
   cond_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready && !cond_pass) |=> !mem_req);

   // R11
   other_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_ready &&
       ((instr_word[6:0] == 7'h00) || (instr_word[6:0] > 7'h06))) |=> !mem_req);

endmodule

bind ldidx_unit ldidx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ldidx_unit_test.sv
module ldidx_unit_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        instr_valid;
   logic        instr_ready;
   logic [31:0] instr_word;
   logic        cond_pass;
   logic [4:0]  base_ridx, offs_ridx;
   logic [31:0] base_rdata, offs_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        mem_err;
   logic        dst_we;
   logic [4:0]  dst_widx;
   logic [31:0] dst_wdata;
   logic        base_we;
   logic [4:0]  base_widx;
   logic [31:0] base_wdata;
   logic        fault;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldidx_unit uut (
      .clk(clk), .rst_n(rst_n),
      .instr_valid(instr_valid), .instr_ready(instr_ready),
      .instr_word(instr_word), .cond_pass(cond_pass),
      .base_ridx(base_ridx), .offs_ridx(offs_ridx),
      .base_rdata(base_rdata), .offs_rdata(offs_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .dst_we(dst_we), .dst_widx(dst_widx), .dst_wdata(dst_wdata),
      .base_we(base_we), .base_widx(base_widx), .base_wdata(base_wdata),
      .fault(fault)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_imm(input logic [6:0] opc, input logic [4:0] dst,
                                           input logic [4:0] src, input logic [10:0] imm);
      return {imm, src, dst, 4'hA, opc};
   endfunction

   function automatic logic [31:0] enc_reg(input logic [6:0] opc, input logic [4:0] dst,
                                           input logic [4:0] src, input logic [4:0] roff,
                                           input logic [5:0] hi);
      return {hi, roff, src, dst, 4'h3, opc};
   endfunction

   // full load sequence; expected values are passed in from the scenario
   task automatic do_load(input string req, input logic [31:0] word,
                          input logic [31:0] base, input logic [31:0] offv,
                          input logic [31:0] rdata, input logic err, input int lat,
                          input logic [31:0] exp_addr, input logic exp_bwe,
                          input logic [31:0] exp_nb);
      @(negedge clk);
      instr_valid = 1'b1; instr_word = word; cond_pass = 1'b1;
      base_rdata = base; offs_rdata = offv;
      #1;
      chk("R1", "base_ridx", {27'd0, base_ridx}, {27'd0, word[20:16]});
      chk("R1", "offs_ridx", {27'd0, offs_ridx}, {27'd0, word[25:21]});
      @(negedge clk);
      instr_valid = 1'b0; base_rdata = ~base; offs_rdata = ~offv;
      chk(req, "mem_req", {31'd0, mem_req}, 32'd1);
      chk(req, "mem_addr", mem_addr, exp_addr);
      chk("R10", "instr_ready busy", {31'd0, instr_ready}, 32'd0);
      for (int i = 0; i < lat; i++) begin
         @(negedge clk);
         chk("R10", "req held", {31'd0, mem_req}, 32'd1);
         chk("R10", "addr held", mem_addr, exp_addr);
      end
      mem_rvalid = 1'b1; mem_rdata = rdata; mem_err = err;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = 32'hDEAD_0000;
      if (err) begin
         chk("R8", "fault", {31'd0, fault}, 32'd1);
         chk("R8", "dst_we", {31'd0, dst_we}, 32'd0);
         chk("R8", "base_we", {31'd0, base_we}, 32'd0);
      end else begin
         chk(req, "dst_we", {31'd0, dst_we}, 32'd1);
         chk(req, "dst_widx", {27'd0, dst_widx}, {27'd0, word[15:11]});
         chk(req, "dst_wdata", dst_wdata, rdata);
         chk(req, "base_we", {31'd0, base_we}, {31'd0, exp_bwe});
         if (exp_bwe) begin
            chk(req, "base_widx", {27'd0, base_widx}, {27'd0, word[20:16]});
            chk(req, "base_wdata", base_wdata, exp_nb);
         end
         chk(req, "fault", {31'd0, fault}, 32'd0);
      end
      chk("R10", "req dropped", {31'd0, mem_req}, 32'd0);
      chk("R10", "ready back", {31'd0, instr_ready}, 32'd1);
      @(negedge clk);
      chk("R10", "strobe width", {29'd0, dst_we, base_we, fault}, 32'd0);
   endtask

   // instruction consumed without any effect
   task automatic do_nop(input string req, input logic [31:0] word, input logic cp);
      @(negedge clk);
      instr_valid = 1'b1; instr_word = word; cond_pass = cp;
      base_rdata = 32'h5000; offs_rdata = 32'h4;
      @(negedge clk);
      instr_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(req, "no req", {31'd0, mem_req}, 32'd0);
         chk(req, "no writes", {30'd0, dst_we, base_we}, 32'd0);
         chk(req, "ready", {31'd0, instr_ready}, 32'd1);
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R12", "mem_req", {31'd0, mem_req}, 32'd0);
      chk("R12", "strobes", {29'd0, dst_we, base_we, fault}, 32'd0);
      chk("R12", "instr_ready", {31'd0, instr_ready}, 32'd1);
   endtask

   task automatic t_pre_imm;
      do_load("R2", enc_imm(7'h01, 5'd3, 5'd7, 11'd5), 32'h1000, 32'h0,
              32'hA1A1_0001, 1'b0, 0, 32'h1014, 1'b0, 32'h0);
   endtask

   task automatic t_prewb_imm;
      do_load("R3", enc_imm(7'h02, 5'd4, 5'd9, 11'd2), 32'h2000, 32'h0,
              32'hB2B2_0002, 1'b0, 1, 32'h2008, 1'b1, 32'h2008);
   endtask

   task automatic t_post_imm;
      do_load("R4", enc_imm(7'h03, 5'd1, 5'd2, 11'd3), 32'h3000, 32'h0,
              32'hC3C3_0003, 1'b0, 3, 32'h3000, 1'b1, 32'h300C);
   endtask

   task automatic t_max_imm;
      do_load("R6", enc_imm(7'h01, 5'd8, 5'd10, 11'h7FF), 32'h0, 32'h0,
              32'h0000_1FFC, 1'b0, 0, 32'h0000_1FFC, 1'b0, 32'h0);
   endtask

   task automatic t_reg_modes;
      do_load("R5", enc_reg(7'h04, 5'd11, 5'd12, 5'd6, 6'h3F), 32'h100, 32'hFFFF_FFF0,
              32'hD4D4_0004, 1'b0, 0, 32'h0000_00F0, 1'b0, 32'h0);
      do_load("R5", enc_reg(7'h05, 5'd13, 5'd14, 5'd15, 6'h15), 32'h400, 32'h40,
              32'hD5D5_0005, 1'b0, 2, 32'h440, 1'b1, 32'h440);
      do_load("R5", enc_reg(7'h06, 5'd16, 5'd17, 5'd18, 6'h2A), 32'h800, 32'h10,
              32'hD6D6_0006, 1'b0, 1, 32'h800, 1'b1, 32'h810);
   endtask

   task automatic t_same_reg;
      do_load("R9", enc_imm(7'h02, 5'd5, 5'd5, 11'd1), 32'h6000, 32'h0,
              32'hE9E9_0009, 1'b0, 0, 32'h6004, 1'b0, 32'h0);
      do_load("R9", enc_reg(7'h06, 5'd20, 5'd20, 5'd21, 6'h0), 32'h7000, 32'h8,
              32'hEAEA_000A, 1'b0, 1, 32'h7000, 1'b0, 32'h0);
   endtask

   task automatic t_fault;
      do_load("R8", enc_imm(7'h03, 5'd22, 5'd23, 11'd4), 32'h9000, 32'h0,
              32'h0BAD_0BAD, 1'b1, 2, 32'h9000, 1'b0, 32'h0);
   endtask

   task automatic t_cond_false;
      do_nop("R7", enc_imm(7'h02, 5'd2, 5'd3, 11'd1), 1'b0);
   endtask

   task automatic t_other_opc;
      do_nop("R11", enc_imm(7'h07, 5'd2, 5'd3, 11'd1), 1'b1);
      do_nop("R11", enc_imm(7'h00, 5'd2, 5'd3, 11'd1), 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; cond_pass = 1'b0;
      base_rdata = '0; offs_rdata = '0; mem_rvalid = 1'b0; mem_rdata = '0; mem_err = 1'b0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_pre_imm;
      t_prewb_imm;
      t_post_imm;
      t_max_imm;
      t_reg_modes;
      t_same_reg;
      t_fault;
      t_cond_false;
      t_other_opc;
      t_pre_imm;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule